// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer Channel

This block is one timer channel with three modes, selected by a 16-bit configuration word. In pulse-output mode it drives a pulse-width-modulated pin whose period and active time come from two count registers. The active level can also swap at the start of every new period. In capture mode it measures the high or low time of a synchronised input pin, and optionally the full cycle of that pin. In edge-count mode it counts rising edges of the same input and raises an event every `period` edges.

A level enable starts the channel on its rising edge and stops it while low. The counter advances on every system clock, or only on cycles flagged by an alternate clock-enable input. A debug-halt input can freeze the counter unless the configuration allows it to keep running. Programming faults and capture overflow are latched in a two-bit error code. Events become a one-cycle interrupt pulse when interrupts are enabled.

Top module: `gp_timer`

## Requirements
- R1: After reset, pwm_out, pad_en, irq, err, cap_width and cap_period are all 0.
- R2: Configuration bits [1:0] select the mode: 00 idle, 01 pulse output, 10 capture, 11 edge count. In idle mode a rising enable starts nothing, pwm_out stays 0, irq stays 0 and err stays 00.
- R3: In pulse-output mode, with bit 2 as the polarity (1 = active high), the run starts the cycle after enable rises. Each period lasts `period` ticks. pwm_out is at the active level for the first `width` ticks and at the inverse level for the rest.
- R4: With bit 6 set, the active level inverts at every period wrap. With bit 6 clear, it stays at the programmed polarity.
- R5: Bit 3 picks the event. With 1, the event is the last tick of each period. With 0, it is the last active tick (width > 0). irq pulses for one cycle after the event.
- R6: With bit 4 clear, irq never rises.
- R7: A pulse-output start with period 0 latches err = 10. A start with width >= period latches err = 11. In both cases the channel does not run and pwm_out stays at the inactive level. A later valid start clears err to 00.
- R8: In capture mode with polarity 1, the number of cycles from a rising to a falling input edge goes to cap_width. With bit 3 set, the cycles from one rising edge to the next go to cap_period. irq pulses at each width capture (bit 3 clear) or each period capture (bit 3 set).
- R9: In capture mode, a measurement that exceeds the counter range latches err = 01.
- R10: In edge-count mode, irq pulses once every `period` rising edges of the input.
- R11: With bit 5 set, counting advances only on cycles where alt_tick is 1.
- R12: While halt is 1 and bit 8 is 0, counting and edge counting freeze. With bit 8 set, halt has no effect.
- R13: pad_en is 1 only in pulse-output mode with bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 16 | Configuration word |
| period | input | CNT_W | Period count |
| width | input | CNT_W | Active-time count |
| en | input | 1 | Channel enable; rising edge starts |
| tin | input | 1 | Input pin for capture and edge count |
| alt_tick | input | 1 | Alternate count enable |
| halt | input | 1 | Debug halt |
| pwm_out | output | 1 | Pulse output pin |
| pad_en | output | 1 | Output driver enable |
| cap_width | output | CNT_W | Captured active time |
| cap_period | output | CNT_W | Captured cycle time |
| irq | output | 1 | One-cycle interrupt pulse |
| err | output | 2 | Latched error code |

## Verification
Pulse output is tried with directed period/width pairs at the edges: width 0, width one below period, and period 1. These show off-by-one errors in the compare and wrap logic. Random settings of polarity, toggle, event selection and interrupt enable follow. Random alt_tick and halt patterns separate real tick gating from free running, because the bench reference advances only on ticks it predicts. Capture is driven with unequal high and low times so that width and period cannot be confused, and with a long pulse that must overflow. Edge counting is driven with edges during and after a halt, which shows whether frozen edges are lost.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_PWM  = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_EXT  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_OVF  = 2'b01,
        ERR_PER  = 2'b10,
        ERR_WID  = 2'b11
    } err_e;

    typedef enum logic [1:0] {
        CS_WAIT   = 2'b00,
        CS_WIDTH  = 2'b01,
        CS_PERIOD = 2'b10
    } cap_st_e;

    typedef struct packed {
        logic [6:0] rsvd;
        logic       run_in_halt;
        logic       pad_off;
        logic       toggle;
        logic       clk_alt;
        logic       irq_en;
        logic       end_sel;
        logic       pol;
        mode_e      mode;
    } cfg_t;

    function automatic err_e prog_err(mode_e m, logic per_zero, logic wid_ge);
        err_e e;
        e = ERR_NONE;
        if (m == MODE_PWM) begin
            if (per_zero)    e = ERR_PER;
            else if (wid_ge) e = ERR_WID;
        end else if (m == MODE_EXT) begin
            if (per_zero)    e = ERR_PER;
        end
        return e;
    endfunction

endpackage

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             alt_tick,
    input  logic             halt,
    input  logic             ovf,
    output logic             run,
    output logic             tick,
    output err_e             err
);
    logic en_q;
    logic start;
    err_e chk;

    assign start = en && !en_q && (cfg.mode != MODE_IDLE);
    assign chk   = prog_err(cfg.mode, period == '0, width >= period);
    assign tick  = (cfg.clk_alt ? alt_tick : 1'b1) && (!halt || cfg.run_in_halt);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            run  <= 1'b0;
            err  <= ERR_NONE;
        end else begin
            en_q <= en;
            if (!en) begin
                run <= 1'b0;
            end else if (start) begin
                err <= chk;
                run <= (chk == ERR_NONE);
            end else if (ovf) begin
                err <= ERR_OVF;
            end
        end
    end

    assert_no_bad_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(run) && $past(cfg.mode) == MODE_PWM |->
            $past(period) != '0 && $past(width) < $past(period));

    assert_ovf_latched_R9: assert property (@(posedge clk) disable iff (rst)
        $past(ovf) && !$past(start) && $past(en) |-> err == ERR_OVF);

endmodule

// File: rtl/gpt_pwm.sv
module gpt_pwm
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             pol,
    input  logic             toggle,
    input  logic             end_sel,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    output logic             pin,
    output logic             evt
);
    logic [CNT_W-1:0] cnt;
    logic             eff_pol;
    logic             last_tick;
    logic             width_end;

    assign last_tick = (cnt == period - 1'b1);
    assign width_end = (width != '0) && (cnt == width - 1'b1);
    assign evt       = run && tick && (end_sel ? last_tick : width_end);
    assign pin       = (run && (cnt < width)) ? eff_pol : !eff_pol;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            eff_pol <= pol;
        end else if (tick) begin
            if (last_tick) begin
                cnt <= '0;
                if (toggle) eff_pol <= !eff_pol;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_halt_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        $past(run) && !$past(tick) |-> $stable(cnt) && $stable(eff_pol));

    assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (rst)
        $past(run) && $past(tick) && $past(toggle) &&
        $past(cnt) == $past(period) - 1'b1 |-> eff_pol != $past(eff_pol));

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             pol,
    input  logic             end_sel,
    input  logic             s_now,
    input  logic             s_prev,
    output logic [CNT_W-1:0] cap_w,
    output logic [CNT_W-1:0] cap_p,
    output logic             evt,
    output logic             ovf
);
    cap_st_e          st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             lead;
    logic             trail;
    logic             wrap;

    assign lead   = (s_now == pol) && (s_prev != pol);
    assign trail  = (s_now != pol) && (s_prev == pol);
    assign cnt_nx = cnt + CNT_W'(tick);
    assign wrap   = tick && (cnt == '1);
    assign ovf    = run && (st != CS_WAIT) && wrap;
    assign evt    = run && !wrap &&
                    (((st == CS_WIDTH) && trail && !end_sel) ||
                     ((st == CS_PERIOD) && lead));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CS_WAIT;
            cnt   <= '0;
            cap_w <= '0;
            cap_p <= '0;
        end else if (!run) begin
            st  <= CS_WAIT;
            cnt <= '0;
        end else begin
            case (st)
                CS_WAIT: begin
                    if (lead) begin
                        st  <= CS_WIDTH;
                        cnt <= '0;
                    end
                end
                CS_WIDTH: begin
                    if (wrap) begin
                        st <= CS_WAIT;
                    end else if (trail) begin
                        cap_w <= cnt_nx;
                        cnt   <= cnt_nx;
                        st    <= end_sel ? CS_PERIOD : CS_WAIT;
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                CS_PERIOD: begin
                    if (wrap) begin
                        st <= CS_WAIT;
                    end else if (lead) begin
                        cap_p <= cnt_nx;
                        cnt   <= '0;
                        st    <= CS_WIDTH;
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                default: st <= CS_WAIT;
            endcase
        end
    end

    assert_period_after_width_R8: assert property (@(posedge clk) disable iff (rst)
        st == CS_PERIOD |-> end_sel || !run || $past(st) == CS_PERIOD || $past(st) == CS_WIDTH);

endmodule

// File: rtl/gpt_extcnt.sv
module gpt_extcnt
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             active,
    input  logic             s_now,
    input  logic             s_prev,
    input  logic [CNT_W-1:0] period,
    output logic             evt
);
    logic [CNT_W-1:0] cnt;
    logic             rise;
    logic             last;

    assign rise = run && active && s_now && !s_prev;
    assign last = (cnt == period - 1'b1);
    assign evt  = rise && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (rise) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    assert_ext_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        evt |=> cnt == '0);

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      cfg,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             en,
    input  logic             tin,
    input  logic             alt_tick,
    input  logic             halt,
    output logic             pwm_out,
    output logic             pad_en,
    output logic [CNT_W-1:0] cap_width,
    output logic [CNT_W-1:0] cap_period,
    output logic             irq,
    output logic [1:0]       err
);
    cfg_t c;
    logic s1, s2, s3;
    logic run, tick, cap_ovf;
    err_e err_st;
    logic pwm_pin, pwm_evt, cap_evt, ext_evt, evt_sel;

    assign c = cfg_t'(cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    gpt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .cfg(c), .en(en), .period(period), .width(width),
        .alt_tick(alt_tick), .halt(halt), .ovf(cap_ovf),
        .run(run), .tick(tick), .err(err_st)
    );

    gpt_pwm #(.CNT_W(CNT_W)) u_pwm (
        .clk(clk), .rst(rst), .run(run && c.mode == MODE_PWM), .tick(tick),
        .pol(c.pol), .toggle(c.toggle), .end_sel(c.end_sel),
        .period(period), .width(width), .pin(pwm_pin), .evt(pwm_evt)
    );

    gpt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .run(run && c.mode == MODE_CAP), .tick(tick),
        .pol(c.pol), .end_sel(c.end_sel), .s_now(s2), .s_prev(s3),
        .cap_w(cap_width), .cap_p(cap_period), .evt(cap_evt), .ovf(cap_ovf)
    );

    gpt_extcnt #(.CNT_W(CNT_W)) u_ext (
        .clk(clk), .rst(rst), .run(run && c.mode == MODE_EXT),
        .active(!halt || c.run_in_halt), .s_now(s2), .s_prev(s3),
        .period(period), .evt(ext_evt)
    );

    always_comb begin
        case (c.mode)
            MODE_PWM: evt_sel = pwm_evt;
            MODE_CAP: evt_sel = cap_evt;
            MODE_EXT: evt_sel = ext_evt;
            default:  evt_sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= c.irq_en && evt_sel;
    end

    assign pwm_out = (c.mode == MODE_PWM) ? pwm_pin : 1'b0;
    assign pad_en  = (c.mode == MODE_PWM) && !c.pad_off;
    assign err     = err_st;

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(c.irq_en));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $past(c.mode) == MODE_IDLE && c.mode == MODE_IDLE |-> !irq && !pwm_out);

endmodule

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [15:0]  cfg;
    logic [W-1:0] period, width;
    logic         en, tin, alt_tick, halt;
    logic         pwm_out, pad_en, irq;
    logic [W-1:0] cap_width, cap_period;
    logic [1:0]   err;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gp_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .cfg(cfg), .period(period), .width(width),
        .en(en), .tin(tin), .alt_tick(alt_tick), .halt(halt),
        .pwm_out(pwm_out), .pad_en(pad_en), .cap_width(cap_width),
        .cap_period(cap_period), .irq(irq), .err(err)
    );

    function automatic logic [15:0] mkcfg(int mode, bit pol, bit es, bit ie,
                                          bit alt, bit tog, bit padoff, bit rih);
        return {7'b0, rih, padoff, tog, alt, ie, es, pol, 2'(mode)};
    endfunction

    function automatic bit exp_pin(int cnt, int w, bit p);
        return (cnt < w) ? p : !p;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pwm_run(input string req, input int p, input int w, input bit pol,
                           input bit tog, input bit es, input bit ie, input bit alt,
                           input bit use_halt, input bit rih, input int ncyc);
        int  m_cnt;
        bit  m_pol, exp_irq, a, h, tk;
        @(negedge clk);
        en = 0; alt_tick = 0; halt = 0;
        cfg = mkcfg(1, pol, es, ie, alt, tog, 0, rih);
        period = W'(p); width = W'(w);
        @(negedge clk);
        en = 1;
        m_cnt = 0; m_pol = pol; exp_irq = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            chk(req, pwm_out, exp_pin(m_cnt, w, m_pol));
            chk(ie ? "R5" : "R6", irq, exp_irq);
            a = alt ? 1'($urandom % 2) : 1'b0;
            h = use_halt ? ($urandom % 3 == 0) : 1'b0;
            alt_tick = a; halt = h;
            tk = (alt ? a : 1'b1) && (!h || rih);
            exp_irq = ie && tk && (es ? (m_cnt == p - 1) : (w != 0 && m_cnt == w - 1));
            if (tk) begin
                if (m_cnt == p - 1) begin
                    m_cnt = 0;
                    if (tog) m_pol = !m_pol;
                end else m_cnt++;
            end
        end
        @(negedge clk);
        en = 0; halt = 0; alt_tick = 0;
    endtask

    task automatic cap_run(input int hi, input int lo, input bit es);
        int pulses;
        @(negedge clk);
        en = 0; tin = 0;
        cfg = mkcfg(2, 1, es, 1, 0, 0, 0, 0);
        @(negedge clk);
        en = 1;
        repeat (4) @(negedge clk);
        pulses = 0;
        for (int k = 0; k < 3; k++) begin
            tin = 1;
            for (int j = 0; j < hi; j++) begin @(negedge clk); pulses += int'(irq); end
            tin = 0;
            for (int j = 0; j < lo; j++) begin @(negedge clk); pulses += int'(irq); end
        end
        for (int j = 0; j < 6; j++) begin @(negedge clk); pulses += int'(irq); end
        chk("R8 width", cap_width, hi);
        if (es) chk("R8 period", cap_period, hi + lo);
        chk("R8 irq count", pulses, es ? 2 : 3);
        chk("R8 no error", err, 0);
        en = 0;
    endtask

    task automatic edges(input int n, inout int pulses);
        for (int k = 0; k < n; k++) begin
            tin = 1;
            repeat (2) begin @(negedge clk); pulses += int'(irq); end
            tin = 0;
            repeat (2) begin @(negedge clk); pulses += int'(irq); end
        end
        repeat (4) begin @(negedge clk); pulses += int'(irq); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'd1234));
        rst = 1; cfg = 0; period = 0; width = 0; en = 0; tin = 0; alt_tick = 0; halt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 pad_en", pad_en, 0);
        chk("R1 irq", irq, 0);
        chk("R1 err", err, 0);
        chk("R1 cap_width", cap_width, 0);
        chk("R1 cap_period", cap_period, 0);

        // R2 idle mode ignores enable and input
        cfg = mkcfg(0, 1, 1, 1, 0, 0, 0, 0); period = 3; width = 1;
        en = 1;
        for (int i = 0; i < 12; i++) begin
            tin = i[1];
            @(negedge clk);
            chk("R2 idle pwm", pwm_out, 0);
            chk("R2 idle irq", irq, 0);
            chk("R2 idle err", err, 0);
        end
        en = 0; tin = 0;

        // R3 .. R6, R11, R12 directed
        pwm_run("R3", 5, 2, 1, 0, 1, 1, 0, 0, 0, 24);
        pwm_run("R3", 6, 4, 0, 0, 1, 1, 0, 0, 0, 24);
        pwm_run("R3", 4, 0, 1, 0, 1, 1, 0, 0, 0, 12);
        pwm_run("R3", 4, 3, 1, 0, 0, 1, 0, 0, 0, 16);
        pwm_run("R3", 1, 0, 0, 1, 1, 1, 0, 0, 0, 8);
        pwm_run("R4", 3, 1, 1, 1, 1, 1, 0, 0, 0, 24);
        pwm_run("R5", 7, 3, 1, 0, 0, 1, 0, 0, 0, 28);
        pwm_run("R6", 4, 2, 1, 0, 1, 0, 0, 0, 0, 16);
        pwm_run("R11", 4, 2, 1, 0, 1, 1, 1, 0, 0, 40);
        pwm_run("R12", 5, 3, 1, 1, 1, 1, 0, 1, 0, 40);
        pwm_run("R12", 5, 3, 0, 0, 0, 1, 0, 1, 1, 40);

        // constrained random pulse-output runs
        for (int r = 0; r < 20; r++) begin
            int p, w;
            p = 1 + int'($urandom % 12);
            w = int'($urandom % p);
            pwm_run("R3", p, w, 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 30);
        end

        // R7 programming errors
        @(negedge clk);
        cfg = mkcfg(1, 1, 1, 1, 0, 0, 0, 0); period = 0; width = 0; en = 1;
        repeat (2) @(negedge clk);
        chk("R7 period zero err", err, 2);
        chk("R7 idle level", pwm_out, 0);
        chk("R7 no irq", irq, 0);
        en = 0;
        @(negedge clk);
        period = 5; width = 5; en = 1;
        repeat (2) @(negedge clk);
        chk("R7 width err", err, 3);
        repeat (4) begin @(negedge clk); chk("R7 held inactive", pwm_out, 0); end
        en = 0;
        @(negedge clk);
        width = 2; en = 1;
        @(negedge clk);
        chk("R7 cleared", err, 0);
        chk("R7 running", pwm_out, 1);
        en = 0;

        // R13 pad enable
        @(negedge clk);
        cfg = mkcfg(1, 1, 1, 0, 0, 0, 0, 0);
        #1 chk("R13 pad on", pad_en, 1);
        cfg = mkcfg(1, 1, 1, 0, 0, 0, 1, 0);
        #1 chk("R13 pad off", pad_en, 0);
        cfg = mkcfg(2, 1, 1, 0, 0, 0, 0, 0);
        #1 chk("R13 capture mode", pad_en, 0);

        // R8 capture
        cap_run(7, 11, 1);
        cap_run(13, 4, 0);
        cap_run(3, 9, 1);

        // R9 overflow
        @(negedge clk);
        en = 0; tin = 0;
        cfg = mkcfg(2, 1, 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        en = 1;
        repeat (3) @(negedge clk);
        tin = 1;
        repeat (300) @(negedge clk);
        chk("R9 overflow err", err, 1);
        tin = 0;
        repeat (4) @(negedge clk);
        en = 0;

        // R10 edge counting, R12 halt freeze
        @(negedge clk);
        cfg = mkcfg(3, 1, 1, 1, 0, 0, 0, 0); period = 3;
        @(negedge clk);
        en = 1;
        repeat (2) @(negedge clk);
        pulses = 0;
        edges(7, pulses);
        chk("R10 pulses per 3 edges", pulses, 2);
        halt = 1;
        pulses = 0;
        edges(5, pulses);
        chk("R12 halted edges ignored", pulses, 0);
        halt = 0;
        pulses = 0;
        edges(1, pulses);
        chk("R10 no early event", pulses, 0);
        edges(1, pulses);
        chk("R10 event after resume", pulses, 1);
        en = 0;

        @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule